// File: doc/BRIEF.md
# Hit-Triggered Channel Reset Timer With Veto

This block times the automatic release of every channel of a multi-channel front end. When a channel's discriminator strobe arrives and the channel is idle, the channel starts holding its captured data and starts its time measurement. A per-channel down counter then runs over a programmable delay. When the delay runs out, the channel gets a one-cycle reset pulse for its time converter and its peak sampler, and it returns to idle. The delay is counted in clock cycles, 10 ns each at 100 MHz. It is set by a 12-bit value, and any value below 30 is raised to 30, which gives a range of 300 ns to about 41 µs.

A user veto can stop the release so that the held values stay available for readout. If the veto is high at the edge where a channel's delay runs out, that channel stays held. It is released only by a manual clear that arrives while the veto is low. A shared stop input ends the time measurement of every running channel. The block also gives a chip-wide flag that is high while any channel holds a hit, and a count of the holding channels. Both outputs follow the channel hold states, so the auto-release clears them too.

Top module: `hit_reset_timer`

## Requirements
- R1: During and after a synchronous active-low reset, all channel reset pulses, hold flags and run flags are 0. The any-hit flag is 0 and the hit count is 0.
- R2: A strobe sampled at an edge while a channel is idle raises that channel's hold flag and run flag after that edge.
- R3: The delay D is the larger of the delay input and 30. It is sampled at the accepting edge. When the veto is low, the channel's reset pulse is high for exactly one cycle, starting after the D-th edge after the accepting edge. The hold flag falls at that same edge, so the hold flag is high for exactly D cycles.
- R4: A strobe on a channel that is already holding has no effect. It does not restart the delay or change the pulse timing.
- R5: If the veto is high at the edge where the delay runs out, no reset pulse is issued and the channel keeps holding.
- R6: A channel held by the veto is released only at an edge where the manual clear is high and the veto is low. That edge produces one reset pulse. A clear at an edge where the veto is high has no effect, and so does a clear on a channel that is not veto-held.
- R7: The stop input ends the run flag of every running channel after the sampling edge. A strobe accepted at the same edge as a stop still starts its run.
- R8: A channel's run flag is 0 whenever the channel is not holding. The reset pulse therefore also clears the run flag.
- R9: The any-hit flag is 1 exactly when at least one channel is holding.
- R10: The hit count equals the number of channels holding, including the channels held by the veto.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns period in the target system |
| rst_n | input | 1 | Synchronous active-low reset |
| delay_cfg | input | 12 | Release delay in clock cycles, raised to 30 if below |
| veto | input | 1 | When high at expiry, the channel is kept held |
| man_clear | input | 1 | Releases veto-held channels while the veto is low |
| stop_all | input | 1 | Shared stop that ends time measurement on all channels |
| fire | input | 32 | Per-channel discriminator strobes |
| chan_reset | output | 32 | One-cycle reset for each channel's time converter and peak sampler |
| chan_hold | output | 32 | Channel holding a hit |
| time_run | output | 32 | Channel time measurement running |
| any_hit | output | 1 | High while any channel holds a hit |
| hit_count | output | 6 | Number of channels holding |

## Verification
Two kinds of event can fall on the same edge. First, a delay can expire on the edge where a new strobe reaches the same channel. Second, a channel can be accepted on the edge where the shared stop arrives, while the veto is also moving around expiry edges. Directed sequences place a strobe inside a running delay and a stop on the accepting edge. Long random runs then use short delays, dense strobes and a toggling veto and clear, so that these overlaps happen often. A cycle-level reference model in the bench judges every cycle. It compares all five outputs against the requirement rules.

// File: rtl/hrt_pkg.sv
// Shared definitions for the hit-triggered reset timer.
// Assumes: nothing beyond IEEE 1800-2017.
package hrt_pkg;
    // Channel life cycle: idle, timing the release delay, held by veto.
    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_TIMING = 2'd1,
        CH_HELD   = 2'd2
    } ch_state_e;
endpackage

// File: rtl/hrt_delay_clamp.sv
// Converts the delay input into the counter load value (D - 1),
// where D is the delay input raised to MIN_DLY when below it.
// Assumes: MIN_DLY >= 1 and fits in DLY_W bits.
module hrt_delay_clamp #(
    parameter int DLY_W   = 12,
    parameter int MIN_DLY = 30
) (
    input  logic [DLY_W-1:0] delay_cfg,
    output logic [DLY_W-1:0] load_val
);
    localparam logic [DLY_W-1:0] MinVal = DLY_W'(MIN_DLY);

    logic [DLY_W-1:0] eff_dly;

    // Raise short delays to the floor, then subtract one for a zero-terminal count.
    always_comb begin
        eff_dly  = (delay_cfg < MinVal) ? MinVal : delay_cfg;
        load_val = eff_dly - DLY_W'(1);
    end
endmodule

// File: rtl/hrt_chan_timer.sv
// One channel: accepts a strobe when idle, counts the release delay,
// then pulses its reset unless the veto holds it; veto-held channels wait
// for a clear with the veto low. Also tracks the time-measurement run flag.
// Assumes: load_val is valid in the cycle the strobe is sampled.
module hrt_chan_timer
    import hrt_pkg::*;
#(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             veto,
    input  logic             man_clear,
    input  logic             stop_all,
    input  logic [DLY_W-1:0] load_val,
    output logic             reset_pulse,
    output logic             holding,
    output logic             running
);
    ch_state_e        state_q;
    logic [DLY_W-1:0] cnt_q;
    logic             accept;
    logic             release_now;
    logic             expire;

    // Decode the events of this cycle from the present state.
    always_comb begin
        accept      = (state_q == CH_IDLE) && fire;
        expire      = (state_q == CH_TIMING) && (cnt_q == '0);
        release_now = (expire && !veto) ||
                      ((state_q == CH_HELD) && man_clear && !veto);
    end

    // Channel state and release-delay counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    if (accept) begin
                        state_q <= CH_TIMING;
                        cnt_q   <= load_val;
                    end
                end
                CH_TIMING: begin
                    if (expire) begin
                        state_q <= veto ? CH_HELD : CH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - DLY_W'(1);
                    end
                end
                CH_HELD: begin
                    if (release_now) state_q <= CH_IDLE;
                end
                default: state_q <= CH_IDLE;
            endcase
        end
    end

    // One-cycle reset pulse toward the converter and peak sampler.
    always_ff @(posedge clk) begin
        if (!rst_n) reset_pulse <= 1'b0;
        else        reset_pulse <= release_now;
    end

    // Run flag: started on accept, ended by shared stop or by release.
    always_ff @(posedge clk) begin
        if (!rst_n)           running <= 1'b0;
        else if (accept)      running <= 1'b1;
        else if (release_now) running <= 1'b0;
        else if (stop_all)    running <= 1'b0;
    end

    assign holding = (state_q != CH_IDLE);
endmodule

// File: rtl/hrt_hit_tally.sv
// Chip-wide hit summary: any-hit flag and population count of holding channels.
// Assumes: CNT_W is wide enough to hold NCH.
module hrt_hit_tally #(
    parameter int NCH   = 32,
    parameter int CNT_W = $clog2(NCH + 1)
) (
    input  logic [NCH-1:0]   hold_vec,
    output logic             any_hit,
    output logic [CNT_W-1:0] hit_count
);
    // Count the holding channels.
    always_comb begin
        hit_count = '0;
        for (int i = 0; i < NCH; i++) begin
            hit_count = hit_count + CNT_W'(hold_vec[i]);
        end
    end

    // Any channel holding.
    assign any_hit = |hold_vec;
endmodule

// File: rtl/hit_reset_timer.sv
// Top: NCH channel timers sharing one clamped delay, veto, clear and stop,
// plus the hit summary. Assumes a single clock domain and synchronous strobes.
module hit_reset_timer #(
    parameter int NCH     = 32,
    parameter int DLY_W   = 12,
    parameter int MIN_DLY = 30,
    localparam int CNT_W  = $clog2(NCH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] delay_cfg,
    input  logic             veto,
    input  logic             man_clear,
    input  logic             stop_all,
    input  logic [NCH-1:0]   fire,
    output logic [NCH-1:0]   chan_reset,
    output logic [NCH-1:0]   chan_hold,
    output logic [NCH-1:0]   time_run,
    output logic             any_hit,
    output logic [CNT_W-1:0] hit_count
);
    logic [DLY_W-1:0] load_val;

    hrt_delay_clamp #(
        .DLY_W  (DLY_W),
        .MIN_DLY(MIN_DLY)
    ) clamp_i (
        .delay_cfg(delay_cfg),
        .load_val (load_val)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        hrt_chan_timer #(
            .DLY_W(DLY_W)
        ) timer_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire       (fire[c]),
            .veto       (veto),
            .man_clear  (man_clear),
            .stop_all   (stop_all),
            .load_val   (load_val),
            .reset_pulse(chan_reset[c]),
            .holding    (chan_hold[c]),
            .running    (time_run[c])
        );
    end

    hrt_hit_tally #(
        .NCH  (NCH),
        .CNT_W(CNT_W)
    ) tally_i (
        .hold_vec (chan_hold),
        .any_hit  (any_hit),
        .hit_count(hit_count)
    );
endmodule

// File: rtl/hit_reset_timer_chk.sv
// Property checker for hit_reset_timer, attached by bind below.
module hit_reset_timer_chk #(
    parameter int NCH   = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             veto,
    input logic             man_clear,
    input logic             stop_all,
    input logic [NCH-1:0]   fire,
    input logic [NCH-1:0]   chan_reset,
    input logic [NCH-1:0]   chan_hold,
    input logic [NCH-1:0]   time_run,
    input logic             any_hit,
    input logic [CNT_W-1:0] hit_count
);
    for (genvar c = 0; c < NCH; c++) begin : g_prop
        AST_ACCEPT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (fire[c] && !chan_hold[c]) |=> (chan_hold[c] && time_run[c])); // R2
        AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            chan_reset[c] |=> !chan_reset[c]); // R3
        AST_PULSE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
            chan_reset[c] |-> !chan_hold[c]); // R3
        AST_NO_PULSE_UNDER_VETO: assert property (@(posedge clk) disable iff (!rst_n)
            chan_reset[c] |-> !$past(veto)); // R5
        AST_HOLD_ENDS_BY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(chan_hold[c]) |-> chan_reset[c]); // R6
        AST_STOP_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(stop_all) && !$past(fire[c] && !chan_hold[c])) |-> !time_run[c]); // R7
        AST_RUN_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_hold[c] |-> !time_run[c]); // R8
    end

    AST_ANY_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit == (hit_count != '0)); // R9
    AST_COUNT_MATCHES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count == CNT_W'($countones(chan_hold))); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (chan_hold == '0 && chan_reset == '0)); // R1
endmodule

bind hit_reset_timer hit_reset_timer_chk #(
    .NCH  (NCH),
    .CNT_W(CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .veto      (veto),
    .man_clear (man_clear),
    .stop_all  (stop_all),
    .fire      (fire),
    .chan_reset(chan_reset),
    .chan_hold (chan_hold),
    .time_run  (time_run),
    .any_hit   (any_hit),
    .hit_count (hit_count)
);

// File: tb/hit_reset_timer_tb_top.sv
// Bench: directed corner cases followed by seeded random traffic,
// judged every cycle against a reference model built from the requirements.
module hit_reset_timer_tb_top;
    localparam int NCH   = 32;
    localparam int DLY_W = 12;
    localparam int MIN_D = 30;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DLY_W-1:0] delay_cfg = '0;
    logic             veto = 1'b0;
    logic             man_clear = 1'b0;
    logic             stop_all = 1'b0;
    logic [NCH-1:0]   fire = '0;
    logic [NCH-1:0]   chan_reset;
    logic [NCH-1:0]   chan_hold;
    logic [NCH-1:0]   time_run;
    logic             any_hit;
    logic [CNT_W-1:0] hit_count;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference model: 0 idle, 1 timing, 2 veto-held.
    int          m_st [NCH];
    int          m_cnt[NCH];
    logic [NCH-1:0] m_rst, m_hold, m_run;

    always #2.5 clk = ~clk;

    hit_reset_timer dut_i (
        .clk(clk), .rst_n(rst_n), .delay_cfg(delay_cfg), .veto(veto),
        .man_clear(man_clear), .stop_all(stop_all), .fire(fire),
        .chan_reset(chan_reset), .chan_hold(chan_hold), .time_run(time_run),
        .any_hit(any_hit), .hit_count(hit_count)
    );

    function automatic int eff_delay(input logic [DLY_W-1:0] cfg);
        return (int'(cfg) < MIN_D) ? MIN_D : int'(cfg);
    endfunction

    function automatic int count_ones(input logic [NCH-1:0] v);
        int n = 0;
        for (int i = 0; i < NCH; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model by one edge using the inputs sampled there.
    task automatic model_edge(input logic r, input logic [DLY_W-1:0] cfg, input logic v,
                              input logic clr, input logic stp, input logic [NCH-1:0] f);
        for (int c = 0; c < NCH; c++) begin
            bit started = 0;
            m_rst[c] = 1'b0;
            if (!r) begin
                m_st[c] = 0; m_cnt[c] = 0; m_run[c] = 1'b0;
            end else begin
                case (m_st[c])
                    0: if (f[c]) begin
                        m_st[c] = 1; m_cnt[c] = eff_delay(cfg) - 1;
                        m_run[c] = 1'b1; started = 1;
                    end
                    1: if (m_cnt[c] == 0) begin
                        if (!v) begin m_st[c] = 0; m_rst[c] = 1'b1; m_run[c] = 1'b0; end
                        else m_st[c] = 2;
                    end else m_cnt[c]--;
                    default: if (clr && !v) begin
                        m_st[c] = 0; m_rst[c] = 1'b1; m_run[c] = 1'b0;
                    end
                endcase
                if (stp && !started) m_run[c] = 1'b0;
            end
            m_hold[c] = (m_st[c] != 0);
        end
    endtask

    // One clock: snapshot inputs, take the edge, update model, compare 1 ns later.
    task automatic step();
        logic r = rst_n; logic [DLY_W-1:0] cfg = delay_cfg; logic v = veto;
        logic clr = man_clear; logic stp = stop_all; logic [NCH-1:0] f = fire;
        @(posedge clk);
        model_edge(r, cfg, v, clr, stp, f);
        #1;
        check("R3/R5/R6 reset pulses", 64'(chan_reset), 64'(m_rst));
        check("R2/R4 hold flags", 64'(chan_hold), 64'(m_hold));
        check("R7/R8 run flags", 64'(time_run), 64'(m_run));
        check("R9 any-hit", 64'(any_hit), 64'(m_hold != '0));
        check("R10 hit count", 64'(hit_count), 64'(count_ones(m_hold)));
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_fire(input int ch);
        fire[ch] = 1'b1; step(); fire[ch] = 1'b0;
    endtask

    initial begin
        #(5 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        #1;
        steps(4);
        check("R1 reset hold", 64'(chan_hold), 64'h0);
        rst_n = 1'b1;
        step();
        check("R1 after reset count", 64'(hit_count), 64'h0);
        check("R1 after reset run", 64'(time_run), 64'h0);

        // R3: short value raised to 30.
        delay_cfg = 12'd10;
        pulse_fire(3);
        check("R2 hold after strobe", 64'(chan_hold[3]), 64'h1);
        steps(MIN_D - 1);
        check("R3 still holding at D-1", 64'(chan_hold[3]), 64'h1);
        step();
        check("R3 pulse at D", 64'(chan_reset[3]), 64'h1);
        check("R3 hold drops with pulse", 64'(chan_hold[3]), 64'h0);

        // R4: a second strobe inside the delay does not restart it.
        delay_cfg = 12'd40;
        pulse_fire(5);
        steps(9);
        pulse_fire(5);
        steps(29);
        check("R4 held before original expiry", 64'(chan_hold[5]), 64'h1);
        step();
        check("R4 pulse at original time", 64'(chan_reset[5]), 64'h1);

        // R5 / R6: veto at expiry keeps the channel, clear releases it.
        veto = 1'b1;
        delay_cfg = 12'd30;
        pulse_fire(7);
        steps(35);
        check("R5 no pulse under veto", 64'(chan_reset[7]), 64'h0);
        check("R5 still held", 64'(chan_hold[7]), 64'h1);
        man_clear = 1'b1; step(); man_clear = 1'b0;
        check("R6 clear ignored with veto high", 64'(chan_hold[7]), 64'h1);
        veto = 1'b0;
        steps(5);
        check("R6 veto drop alone does not release", 64'(chan_hold[7]), 64'h1);
        man_clear = 1'b1; step(); man_clear = 1'b0;
        check("R6 clear releases", 64'(chan_reset[7]), 64'h1);
        check("R10 count after release", 64'(hit_count), 64'h0);

        // R7: strobe and stop at the same edge; later stop ends the run.
        stop_all = 1'b1; fire[1] = 1'b1; step(); fire[1] = 1'b0; stop_all = 1'b0;
        check("R7 run starts despite stop", 64'(time_run[1]), 64'h1);
        steps(3);
        stop_all = 1'b1; step(); stop_all = 1'b0;
        check("R7 stop ends run", 64'(time_run[1]), 64'h0);
        check("R7 stop keeps hold", 64'(chan_hold[1]), 64'h1);
        // R8: release clears the run flag.
        pulse_fire(2);
        steps(MIN_D);
        check("R8 run cleared on release", 64'(time_run[2]), 64'h0);
        steps(5);

        // R3: full-width delay.
        delay_cfg = 12'hFFF;
        pulse_fire(0);
        steps(4095 - 1);
        check("R3 long delay held", 64'(chan_hold[0]), 64'h1);
        step();
        check("R3 long delay pulse", 64'(chan_reset[0]), 64'h1);

        // Random traffic with dense overlaps.
        for (int cyc = 0; cyc < 6000; cyc++) begin
            if (cyc % 97 == 0) delay_cfg = DLY_W'($urandom_range(0, 70));
            for (int c = 0; c < NCH; c++) fire[c] = ($urandom_range(0, 39) == 0);
            if ($urandom_range(0, 29) == 0) veto = ~veto;
            man_clear = ($urandom_range(0, 15) == 0);
            stop_all  = ($urandom_range(0, 24) == 0);
            if (cyc == 3000) rst_n = 1'b0;
            if (cyc == 3003) rst_n = 1'b1;
            step();
        end
        fire = '0;

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule